// File: doc/BRIEF.md
# Power Mode Control Unit

This block holds the byte-wide power-control register of a small 8-bit microcontroller and runs the clock-gating state machine behind it. Software moves the chip between three modes by writing that register over the special-function-register bus. In run mode both clock enables are high. In idle the CPU clock enable drops, the peripheral clock enable (timers, serial port, interrupt logic) stays high, and all CPU state is kept. In power-down both enables drop. This stands in for a stopped oscillator.

Idle and power-down leave by different paths. Idle ends on an enabled, pending interrupt, which also clears the idle bit in hardware. Idle also ends on a qualified reset. Power-down ignores interrupts and ends only on a qualified reset. A qualified reset needs the raw reset pin sampled high on a set number of consecutive reference-clock edges, equal to two machine cycles. The block also sets the levels of the address-latch and program-store strobes while the core is asleep. It drives an asynchronous "force port latches to one" line straight from the reset pin.

The `clk` input is the free-running reference, so the reset qualifier can still count during power-down. The `rst` input is the chip's synchronous active-high reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After `rst`, or after a qualified reset, the register reads 0x00. The mode is run (code 0), and both clock enables are 1.
- R2: The register sits at bus address SFR_ADDR (default 0x87) and is written only as a whole byte. Bit 7 is the double-baud flag, shown on `baud_dbl`. Bits 3 and 2 are general-purpose flags. Bit 1 requests power-down and bit 0 requests idle. Bits 6..4 are reserved and read as 0. Writes to any other address change nothing, and reads of any other address return 0.
- R3: A write with bit 0 = 1 and bit 1 = 0, made in run mode, enters idle (code 1) on that clock edge: `cpu_clk_en` = 0 and `per_clk_en` = 1.
- R4: A write with bit 1 = 1, made in run mode, enters power-down (code 2) with both clock enables 0. If bit 0 is also 1, power-down wins and bit 0 reads back as 0.
- R5: In idle, `int_pend` = 1 on a clock edge returns the mode to run, clears bit 0 and leaves the flag bits unchanged.
- R6: `int_pend` has no effect in run mode or in power-down. Power-down is left only through a qualified reset.
- R7: Register writes made in idle or power-down are ignored.
- R8: `core_rst` rises after QUAL_MC*OSC_PER_MC consecutive clock edges on which `rst_pin` is high. If the pin falls before that count, the count starts again from zero. `core_rst` clears the register and returns the mode to run on the next edge, from idle or from power-down.
- R9: `ale_o`/`psen_o` follow `core_ale`/`core_psen` in run mode. In idle both are 1, and in power-down both are 0.
- R10: `port_force_ones` equals `rst_pin` with no clock edge between them.
- R11: `mode_o` only ever shows the codes 0 (run), 1 (idle) or 2 (power-down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high chip reset |
| rst_pin | input | 1 | Raw external reset pin |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_rd | input | 1 | SFR read strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (0 when not selected) |
| int_pend | input | 1 | An enabled interrupt is pending |
| core_ale | input | 1 | Address-latch strobe level from the core |
| core_psen | input | 1 | Program-store strobe level from the core |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode_o | output | 2 | Mode: 0 run, 1 idle, 2 power-down |
| baud_dbl | output | 1 | Double-baud flag to the serial port |
| ale_o | output | 1 | Address-latch strobe pin level |
| psen_o | output | 1 | Program-store strobe pin level |
| core_rst | output | 1 | Qualified reset to the core |
| port_force_ones | output | 1 | Asynchronous set of the I/O port latches |

## Verification
The bench builds the block with OSC_PER_MC = 4 and QUAL_MC = 2, so the reset qualifier needs 8 consecutive high samples instead of 24. With that threshold the cycle on which `core_rst` rises can be counted exactly. The restart after an early pin drop, and the exits from idle and power-down by reset, all fit in short directed scenarios. SFR_ADDR stays at its default 0x87, and a neighbouring address is used to show that writes to it miss the register.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_PDOWN = 2'd2
    } pm_mode_e;

    // Bit positions of the control byte
    localparam int unsigned POS_BAUD = 7;
    localparam int unsigned POS_GPF1 = 3;
    localparam int unsigned POS_GPF0 = 2;
    localparam int unsigned POS_PDN  = 1;
    localparam int unsigned POS_IDL  = 0;

    typedef struct packed {
        logic baud;
        logic gpf1;
        logic gpf0;
        logic pdn;
        logic idl;
    } pmreg_t;

    localparam pmreg_t PMREG_RESET = '{baud: 1'b0, gpf1: 1'b0, gpf0: 1'b0, pdn: 1'b0, idl: 1'b0};

    // Decode a written byte; a power-down request suppresses the idle request.
    function automatic pmreg_t byte_to_reg(input logic [7:0] b);
        pmreg_t r;
        r.baud = b[POS_BAUD];
        r.gpf1 = b[POS_GPF1];
        r.gpf0 = b[POS_GPF0];
        r.pdn  = b[POS_PDN];
        r.idl  = b[POS_IDL] & ~b[POS_PDN];
        return r;
    endfunction

    // Reserved positions read as zero.
    function automatic logic [7:0] reg_to_byte(input pmreg_t r);
        logic [7:0] b;
        b = '0;
        b[POS_BAUD] = r.baud;
        b[POS_GPF1] = r.gpf1;
        b[POS_GPF0] = r.gpf0;
        b[POS_PDN]  = r.pdn;
        b[POS_IDL]  = r.idl;
        return b;
    endfunction

    function automatic pm_mode_e mode_from_req(input pmreg_t r, input pm_mode_e cur);
        if (r.pdn)      return PM_PDOWN;
        else if (r.idl) return PM_IDLE;
        else            return cur;
    endfunction

endpackage

// File: rtl/pmc_rst_qual.sv
module pmc_rst_qual #(
    parameter int unsigned THRESH = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic qual
);
    localparam int unsigned CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESH);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!pin) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign qual = (cnt_q == LIMIT);
endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pwr_mode_pkg::*;
#(
    parameter logic [7:0] ADDR = 8'h87
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       wr_allow,
    input  logic [7:0] addr,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] wdata,
    input  logic       idle_exit,
    output logic [7:0] rdata,
    output logic       wr_go,
    output pmreg_t     wr_fields,
    output pmreg_t     reg_q
);
    logic hit;

    assign hit       = (addr == ADDR);
    assign wr_go     = wr & hit & wr_allow;
    assign wr_fields = byte_to_reg(wdata);

    always_ff @(posedge clk) begin
        if (clr) begin
            reg_q <= PMREG_RESET;
        end else if (wr_go) begin
            reg_q <= wr_fields;
        end else if (idle_exit) begin
            reg_q.idl <= 1'b0;
        end
    end

    assign rdata = (rd && hit) ? reg_to_byte(reg_q) : 8'h00;
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  logic     wr_go,
    input  pmreg_t   wr_fields,
    input  logic     int_pend,
    output pm_mode_e mode,
    output logic     wr_allow,
    output logic     idle_exit,
    output logic     cpu_clk_en,
    output logic     per_clk_en
);
    pm_mode_e mode_q, mode_d;

    always_comb begin
        mode_d    = mode_q;
        idle_exit = 1'b0;
        unique case (mode_q)
            PM_RUN: begin
                if (wr_go) mode_d = mode_from_req(wr_fields, PM_RUN);
            end
            PM_IDLE: begin
                if (int_pend) begin
                    mode_d    = PM_RUN;
                    idle_exit = 1'b1;
                end
            end
            PM_PDOWN: mode_d = PM_PDOWN;
            default:  mode_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) mode_q <= PM_RUN;
        else     mode_q <= mode_d;
    end

    assign mode       = mode_q;
    assign wr_allow   = (mode_q == PM_RUN);
    assign cpu_clk_en = (mode_q == PM_RUN);
    assign per_clk_en = (mode_q != PM_PDOWN);
endmodule

// File: rtl/pmc_strobe_drv.sv
module pmc_strobe_drv
    import pwr_mode_pkg::*;
#(
    parameter int unsigned NSTROBE = 2
) (
    input  pm_mode_e           mode,
    input  logic [NSTROBE-1:0] core_lvl,
    output logic [NSTROBE-1:0] pin_lvl
);
    for (genvar i = 0; i < NSTROBE; i++) begin : g_strobe
        always_comb begin
            unique case (mode)
                PM_IDLE:  pin_lvl[i] = 1'b1;
                PM_PDOWN: pin_lvl[i] = 1'b0;
                default:  pin_lvl[i] = core_lvl[i];
            endcase
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter logic [7:0]  SFR_ADDR   = 8'h87,
    parameter int unsigned OSC_PER_MC = 12,
    parameter int unsigned QUAL_MC    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rst_pin,
    input  logic [7:0] sfr_addr,
    input  logic       sfr_wr,
    input  logic       sfr_rd,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    input  logic       int_pend,
    input  logic       core_ale,
    input  logic       core_psen,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic [1:0] mode_o,
    output logic       baud_dbl,
    output logic       ale_o,
    output logic       psen_o,
    output logic       core_rst,
    output logic       port_force_ones
);
    localparam int unsigned QUAL_CYC = OSC_PER_MC * QUAL_MC;

    logic     clr;
    logic     wr_allow, wr_go, idle_exit;
    pmreg_t   wr_fields, reg_q;
    pm_mode_e mode;
    logic [1:0] strobe_out;

    pmc_rst_qual #(.THRESH(QUAL_CYC)) u_qual (
        .clk (clk),
        .rst (rst),
        .pin (rst_pin),
        .qual(core_rst)
    );

    assign clr = rst | core_rst;

    pmc_ctrl_reg #(.ADDR(SFR_ADDR)) u_reg (
        .clk      (clk),
        .clr      (clr),
        .wr_allow (wr_allow),
        .addr     (sfr_addr),
        .wr       (sfr_wr),
        .rd       (sfr_rd),
        .wdata    (sfr_wdata),
        .idle_exit(idle_exit),
        .rdata    (sfr_rdata),
        .wr_go    (wr_go),
        .wr_fields(wr_fields),
        .reg_q    (reg_q)
    );

    pmc_mode_fsm u_fsm (
        .clk       (clk),
        .clr       (clr),
        .wr_go     (wr_go),
        .wr_fields (wr_fields),
        .int_pend  (int_pend),
        .mode      (mode),
        .wr_allow  (wr_allow),
        .idle_exit (idle_exit),
        .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en)
    );

    pmc_strobe_drv #(.NSTROBE(2)) u_strobe (
        .mode    (mode),
        .core_lvl({core_psen, core_ale}),
        .pin_lvl (strobe_out)
    );

    assign ale_o           = strobe_out[0];
    assign psen_o          = strobe_out[1];
    assign mode_o          = mode;
    assign baud_dbl        = reg_q.baud;
    assign port_force_ones = rst_pin;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter logic [7:0] SFR_ADDR = 8'h87
) (
    input logic       clk,
    input logic       rst,
    input logic       rst_pin,
    input logic [7:0] sfr_addr,
    input logic       sfr_wr,
    input logic [7:0] sfr_wdata,
    input logic       int_pend,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic [1:0] mode_o,
    input logic       ale_o,
    input logic       psen_o,
    input logic       core_rst
);
    assert_idle_clocks_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd1) |-> (!cpu_clk_en && per_clk_en));

    assert_pdown_clocks_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |-> (!cpu_clk_en && !per_clk_en));

    assert_pdown_wins_R4: assert property (@(posedge clk) disable iff (rst)
        (sfr_wr && sfr_addr == SFR_ADDR && sfr_wdata[1] && mode_o == 2'd0 && !core_rst)
        |=> (mode_o == 2'd2));

    assert_int_wakes_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd1 && int_pend && !core_rst) |=> (mode_o == 2'd0));

    assert_pdown_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2 && !core_rst) |=> (mode_o == 2'd2));

    assert_core_rst_from_pin_R8: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> $past(rst_pin));

    assert_core_rst_clears_R8: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> (mode_o == 2'd0 && cpu_clk_en));

    assert_strobe_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd1) |-> (ale_o && psen_o));

    assert_strobe_pdown_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |-> (!ale_o && !psen_o));

    assert_mode_code_R11: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'd3);
endmodule

bind pwr_mode_ctrl pmc_checker #(.SFR_ADDR(SFR_ADDR)) i_pmc_checker (
    .clk       (clk),
    .rst       (rst),
    .rst_pin   (rst_pin),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .int_pend  (int_pend),
    .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en),
    .mode_o    (mode_o),
    .ale_o     (ale_o),
    .psen_o    (psen_o),
    .core_rst  (core_rst)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
    localparam int THR = 8;   // OSC_PER_MC(4) * QUAL_MC(2)

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_pin = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic       sfr_rd = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic       int_pend = 1'b0;
    logic       core_ale = 1'b0;
    logic       core_psen = 1'b0;
    logic [7:0] sfr_rdata;
    logic       cpu_clk_en, per_clk_en, baud_dbl, ale_o, psen_o, core_rst, port_force_ones;
    logic [1:0] mode_o;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.SFR_ADDR(8'h87), .OSC_PER_MC(4), .QUAL_MC(2)) i_pwr_mode_ctrl (
        .clk(clk), .rst(rst), .rst_pin(rst_pin),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
        .int_pend(int_pend), .core_ale(core_ale), .core_psen(core_psen),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .mode_o(mode_o),
        .baud_dbl(baud_dbl), .ale_o(ale_o), .psen_o(psen_o),
        .core_rst(core_rst), .port_force_ones(port_force_ones)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a; sfr_rd = 1'b1;
        #0.5;
        d = sfr_rdata;
        sfr_rd = 1'b0;
    endtask

    task automatic pulse_int(input int n);
        @(negedge clk);
        int_pend = 1'b1;
        repeat (n) @(negedge clk);
        int_pend = 1'b0;
    endtask

    task automatic t_reset_state;
        logic [7:0] d;
        sfr_read(8'h87, d);
        check("R1", "reg after reset", d, 8'h00);
        check("R1", "mode after reset", mode_o, 0);
        check("R1", "cpu_clk_en", cpu_clk_en, 1);
        check("R1", "per_clk_en", per_clk_en, 1);
    endtask

    task automatic t_register_map;
        logic [7:0] d;
        sfr_write(8'h87, 8'hFC);
        sfr_read(8'h87, d);
        check("R2", "reserved read zero", d, 8'h8C);
        check("R2", "baud_dbl", baud_dbl, 1);
        check("R2", "mode after flag write", mode_o, 0);
        sfr_write(8'h88, 8'h03);
        sfr_read(8'h87, d);
        check("R2", "other address write", d, 8'h8C);
        check("R2", "other address no mode", mode_o, 0);
        sfr_read(8'h88, d);
        check("R2", "other address read", d, 8'h00);
        sfr_write(8'h87, 8'h00);
        check("R2", "baud_dbl cleared", baud_dbl, 0);
    endtask

    task automatic t_idle_interrupt;
        logic [7:0] d;
        sfr_write(8'h87, 8'h0D);
        check("R3", "idle mode", mode_o, 1);
        check("R3", "cpu gated", cpu_clk_en, 0);
        check("R3", "per running", per_clk_en, 1);
        sfr_write(8'h87, 8'h02);
        check("R7", "write in idle ignored", mode_o, 1);
        sfr_read(8'h87, d);
        check("R7", "reg in idle", d, 8'h0D);
        pulse_int(1);
        check("R5", "wake mode", mode_o, 0);
        check("R5", "cpu restored", cpu_clk_en, 1);
        sfr_read(8'h87, d);
        check("R5", "idle bit cleared, flags kept", d, 8'h0C);
        pulse_int(2);
        check("R6", "int in run ignored", mode_o, 0);
        sfr_read(8'h87, d);
        check("R6", "reg after int in run", d, 8'h0C);
    endtask

    task automatic t_strobes;
        @(negedge clk);
        core_ale = 1'b1; core_psen = 1'b0;
        #0.5;
        check("R9", "run ale pass", ale_o, 1);
        check("R9", "run psen pass", psen_o, 0);
        core_ale = 1'b0; core_psen = 1'b1;
        #0.5;
        check("R9", "run ale pass 2", ale_o, 0);
        check("R9", "run psen pass 2", psen_o, 1);
        core_ale = 1'b0; core_psen = 1'b0;
        sfr_write(8'h87, 8'h01);
        check("R9", "idle ale high", ale_o, 1);
        check("R9", "idle psen high", psen_o, 1);
        pulse_int(1);
        core_ale = 1'b1; core_psen = 1'b1;
        sfr_write(8'h87, 8'h02);
        check("R9", "pdown ale low", ale_o, 0);
        check("R9", "pdown psen low", psen_o, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        core_ale = 1'b0; core_psen = 1'b0;
        check("R1", "sync reset leaves pdown", mode_o, 0);
    endtask

    task automatic t_pdown_priority;
        logic [7:0] d;
        sfr_write(8'h87, 8'h83);
        check("R4", "pdown mode", mode_o, 2);
        check("R4", "cpu off", cpu_clk_en, 0);
        check("R4", "per off", per_clk_en, 0);
        sfr_read(8'h87, d);
        check("R4", "idle bit dropped", d, 8'h82);
        pulse_int(3);
        check("R6", "int in pdown ignored", mode_o, 2);
        check("R6", "per still off", per_clk_en, 0);
        sfr_write(8'h87, 8'h00);
        check("R7", "write in pdown ignored", mode_o, 2);
        sfr_read(8'h87, d);
        check("R7", "reg in pdown", d, 8'h82);
    endtask

    task automatic t_reset_qualifier;
        logic [7:0] d;
        @(negedge clk);
        rst_pin = 1'b1;
        #0.5;
        check("R10", "port force follows pin", port_force_ones, 1);
        repeat (THR - 1) @(negedge clk);
        check("R8", "no qual before threshold", core_rst, 0);
        rst_pin = 1'b0;
        #0.5;
        check("R10", "port force released", port_force_ones, 0);
        repeat (2) @(negedge clk);
        check("R8", "count restarted, still pdown", mode_o, 2);
        rst_pin = 1'b1;
        repeat (THR - 1) @(negedge clk);
        check("R8", "restart needs full count", core_rst, 0);
        @(negedge clk);
        check("R8", "qual at threshold", core_rst, 1);
        check("R8", "mode before clear edge", mode_o, 2);
        @(negedge clk);
        check("R8", "pdown exit by reset", mode_o, 0);
        sfr_read(8'h87, d);
        check("R8", "reg cleared by reset", d, 8'h00);
        check("R8", "baud cleared", baud_dbl, 0);
        rst_pin = 1'b0;
        repeat (2) @(negedge clk);
        sfr_write(8'h87, 8'h05);
        check("R3", "idle again", mode_o, 1);
        @(negedge clk);
        rst_pin = 1'b1;
        repeat (THR + 1) @(negedge clk);
        check("R8", "idle exit by reset", mode_o, 0);
        sfr_read(8'h87, d);
        check("R8", "flags cleared by reset", d, 8'h00);
        rst_pin = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_register_map();
        t_idle_interrupt();
        t_strobes();
        t_pdown_priority();
        t_reset_qualifier();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule